// File: doc/BRIEF.md
# Dual-Oscillator Edge-Order Range Monitor

This block supervises a capacitance-to-time sigma-delta loop from the digital side. It watches two free-running oscillator outputs, a signal oscillator and a reference oscillator, together with the single-bit quantizer output of the loop. All three inputs come from outside the fast sampling clock domain, so each one passes through a synchroniser before any logic uses it. The block then finds the rising edges of both oscillators and tracks the order in which they arrive.

While the loop is linear, the rising edges of the two oscillators alternate: exactly one reference rising edge falls between two signal rising edges. The monitor counts reference rising edges between signal rising edges. At every signal rising edge it reports that count and the quantizer bit. It raises one of two sticky flags as soon as the alternation breaks. Two signal edges with no reference edge between them mean the sensed input is below the usable range. Two reference edges with no signal edge between them mean it is above the usable range. The flags run alongside normal sensing, so downstream logic can mark conversion data invalid from the cycle an error pattern shows up.

Top module: `osc_range_monitor`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), under_range_o, over_range_o, sample_valid_o, sample_bit_o and ref_gap_o are all 0.
- R2: Once armed, two signal rising edges with no reference rising edge between them set under_range_o.
- R3: If the reference input holds one constant level (high or low) across two signal rising edges, under_range_o is set.
- R4: Once armed, a second reference rising edge with no signal rising edge since the first sets over_range_o. This happens at that reference edge, and it happens when the quantizer bit is 1 as well as when it is 0.
- R5: While the two oscillators run at equal periods, so that their rising edges alternate, neither flag is set.
- R6: Each flag stays set until clear_i is sampled high. A cycle with clear_i high zeroes both flags, sample_valid_o, sample_bit_o, ref_gap_o, the reference-edge count and the armed state. Clear wins over any detection in the same cycle.
- R7: While one flag is set, the other flag cannot be set; only a clear removes this lock.
- R8: The monitor is armed by the first signal rising edge after reset or clear. Reference edges before that edge set no flag.
- R9: At each signal rising edge, sample_valid_o is high for exactly one cycle. In that cycle sample_bit_o holds the synchronised quantizer bit, and ref_gap_o holds the number of reference rising edges since the previous signal rising edge (or since reset or clear), saturated at 2 (0 = none, 1 = one, 2 = two or more). A reference rising edge in the same cycle as a signal rising edge counts as arriving before it. sample_bit_o and ref_gap_o hold their values until the next signal rising edge.
- R10: With SYNC_STAGES = 2, an input level presented before clock edge k shows at the outputs after edge k+2. clear_i is not synchronised and acts at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of flags and edge-order state |
| sig_osc_i | input | 1 | Signal oscillator output, asynchronous |
| ref_osc_i | input | 1 | Reference oscillator output, asynchronous |
| mod_bit_i | input | 1 | Quantizer output bit, asynchronous |
| under_range_o | output | 1 | Sticky flag: input below the linear range |
| over_range_o | output | 1 | Sticky flag: input above the linear range |
| sample_valid_o | output | 1 | One-cycle pulse per signal rising edge |
| sample_bit_o | output | 1 | Quantizer bit captured at the last signal rising edge |
| ref_gap_o | output | 2 | Reference rising edges seen before the last signal rising edge, saturated at 2 |

## Verification
Every oscillator and quantizer result is due three clock edges after the input level is driven: two synchroniser flops, then the tracker register. A clear takes effect at the very next edge. The bench drives inputs on the falling clock edge. Its own model of the edge-order rules takes the levels driven two steps earlier and the clear driven in the same step, and it compares the model against the outputs on the following falling edge, every cycle. Named checks at the end of each directed and random scenario confirm the expected flag, the captured bit and the gap code after the pipeline has drained.

// File: rtl/orm_pkg.sv
// Package: shared widths and codes for the oscillator range monitor.
// Assumes: gap codes saturate at GAP_MULTI; lane order of the synchroniser
// vector is fixed by the LANE_* constants below.
package orm_pkg;

    // Width of the reference-edge gap code.
    localparam int GAP_W = 2;

    // Number of asynchronous inputs that go through the synchroniser.
    localparam int N_LANES = 3;

    // Lane positions inside the synchronised vector.
    localparam int LANE_SIG = 0;
    localparam int LANE_REF = 1;
    localparam int LANE_MOD = 2;

    // Number of reference rising edges seen between signal rising edges.
    typedef enum logic [GAP_W-1:0] {
        GAP_NONE  = 2'd0,
        GAP_ONE   = 2'd1,
        GAP_MULTI = 2'd2
    } gap_code_e;

endpackage

// File: rtl/orm_sync.sv
// Module: orm_sync
// Multi-lane flop-chain synchroniser for asynchronous level inputs.
// Assumes: each input level is held for longer than STAGES clock periods,
// so that one-cycle glitches at the output cannot matter.
module orm_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    // One flop chain per stage; stage 0 captures the raw inputs.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: sample the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= async_i;
                end
            end else begin : g_next
                // Later stages: shift the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= '0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/orm_rise_detect.sv
// Module: orm_rise_detect
// Per-lane rising-edge detector on already synchronised levels.
// Assumes: inputs are synchronous to clk; the output pulse is combinational
// and lasts one cycle per low-to-high change.
module orm_rise_detect #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] level_i,
    output logic [LANES-1:0] rise_o
);

    logic [LANES-1:0] prev_q;

    // Keep the previous sample of every lane.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    // Rising edge: high now, low one cycle ago.
    assign rise_o = level_i & ~prev_q;

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_chk
            // R9: a rising-edge pulse never lasts two cycles
            rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[l] |=> !rise_o[l]);
        end
    endgenerate

endmodule

// File: rtl/orm_order_tracker.sv
// Module: orm_order_tracker
// Counts reference rising edges between signal rising edges, captures the
// quantizer bit at each signal edge and raises the sticky range flags.
// Assumes: rising-edge pulses are synchronous one-cycle pulses; a reference
// pulse in the same cycle as a signal pulse is counted before it.
module orm_order_tracker
    import orm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             sig_rise_i,
    input  logic             ref_rise_i,
    input  logic             mod_bit_i,
    output logic             under_o,
    output logic             over_o,
    output logic             valid_o,
    output logic             bit_o,
    output logic [GAP_W-1:0] gap_o
);

    logic             armed_q;
    gap_code_e        cnt_q;
    gap_code_e        cnt_eff;
    logic             under_q, over_q;
    logic             valid_q, bit_q;
    logic [GAP_W-1:0] gap_q;
    logic             under_hit, over_hit;

    // Reference count including a reference edge in this same cycle.
    always_comb begin
        cnt_eff = cnt_q;
        if (ref_rise_i) begin
            case (cnt_q)
                GAP_NONE: cnt_eff = GAP_ONE;
                default:  cnt_eff = GAP_MULTI;
            endcase
        end
    end

    // Error patterns, valid only once armed by a first signal edge.
    always_comb begin
        under_hit = armed_q && sig_rise_i && (cnt_eff == GAP_NONE);
        over_hit  = armed_q && (cnt_eff == GAP_MULTI);
    end

    // Edge-order state: arming and the reference-edge count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            armed_q <= 1'b0;
            cnt_q   <= GAP_NONE;
        end else if (sig_rise_i) begin
            armed_q <= 1'b1;
            cnt_q   <= GAP_NONE;
        end else begin
            cnt_q   <= cnt_eff;
        end
    end

    // Sticky flags; the first one set locks out the other.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            under_q <= 1'b0;
            over_q  <= 1'b0;
        end else begin
            if (under_hit && !over_q) under_q <= 1'b1;
            if (over_hit && !under_q) over_q  <= 1'b1;
        end
    end

    // Per-signal-edge sample: valid pulse, quantizer bit and gap code.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            valid_q <= 1'b0;
            bit_q   <= 1'b0;
            gap_q   <= '0;
        end else begin
            valid_q <= sig_rise_i;
            if (sig_rise_i) begin
                bit_q <= mod_bit_i;
                gap_q <= cnt_eff;
            end
        end
    end

    assign under_o = under_q;
    assign over_o  = over_q;
    assign valid_o = valid_q;
    assign bit_o   = bit_q;
    assign gap_o   = gap_q;

    // R7
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(under_q && over_q));

    // R6
    under_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (under_q && !clear_i) |=> under_q);

    // R6
    over_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (over_q && !clear_i) |=> over_q);

    // R6
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!under_q && !over_q && !valid_q && gap_q == '0));

    // R9
    valid_follows_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(sig_rise_i));

    // R8
    unarmed_no_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_q && !over_q && !sig_rise_i) |=> !over_q);

endmodule

// File: rtl/osc_range_monitor.sv
// Module: osc_range_monitor (top)
// Synchronises two oscillator outputs and a quantizer bit, detects rising
// edges on both oscillators and checks that they alternate; flags under-
// and over-range of a sigma-delta capacitance loop.
// Assumes: each oscillator half-period spans at least SYNC_STAGES+1 clk
// cycles; clear_i is synchronous to clk.
module osc_range_monitor
    import orm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             sig_osc_i,
    input  logic             ref_osc_i,
    input  logic             mod_bit_i,
    output logic             under_range_o,
    output logic             over_range_o,
    output logic             sample_valid_o,
    output logic             sample_bit_o,
    output logic [GAP_W-1:0] ref_gap_o
);

    localparam int N_EDGE = 2;

    logic [N_LANES-1:0] raw_in;
    logic [N_LANES-1:0] sync_lv;
    logic [N_EDGE-1:0]  rise;

    // Gather asynchronous inputs in lane order.
    always_comb begin
        raw_in           = '0;
        raw_in[LANE_SIG] = sig_osc_i;
        raw_in[LANE_REF] = ref_osc_i;
        raw_in[LANE_MOD] = mod_bit_i;
    end

    orm_sync #(
        .WIDTH  (N_LANES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_lv)
    );

    orm_rise_detect #(
        .LANES (N_EDGE)
    ) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({sync_lv[LANE_REF], sync_lv[LANE_SIG]}),
        .rise_o  (rise)
    );

    orm_order_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .sig_rise_i (rise[0]),
        .ref_rise_i (rise[1]),
        .mod_bit_i  (sync_lv[LANE_MOD]),
        .under_o    (under_range_o),
        .over_o     (over_range_o),
        .valid_o    (sample_valid_o),
        .bit_o      (sample_bit_o),
        .gap_o      (ref_gap_o)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!under_range_o && !over_range_o && !sample_valid_o));

endmodule

// File: tb/tb_osc_range_monitor.sv
// Bench for osc_range_monitor: directed scenarios plus seeded random period
// ratios, all compared each cycle against a bench model of the rules.
module tb_osc_range_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       sig_osc_i = 1'b0;
    logic       ref_osc_i = 1'b0;
    logic       mod_bit_i = 1'b0;
    logic       under_range_o, over_range_o, sample_valid_o, sample_bit_o;
    logic [1:0] ref_gap_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_en = 1'b0;

    // Driven-level history: index 0 is the newest.
    logic h_sig [4];
    logic h_ref [4];
    logic h_mod [4];

    // Model state.
    bit       m_armed, m_under, m_over, m_valid, m_bit;
    int       m_cnt;
    int       m_gap;

    always #5 clk = ~clk;

    osc_range_monitor dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (clear_i),
        .sig_osc_i      (sig_osc_i),
        .ref_osc_i      (ref_osc_i),
        .mod_bit_i      (mod_bit_i),
        .under_range_o  (under_range_o),
        .over_range_o   (over_range_o),
        .sample_valid_o (sample_valid_o),
        .sample_bit_o   (sample_bit_o),
        .ref_gap_o      (ref_gap_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Model of one clock edge from the requirements (R2..R9).
    task automatic model_step(input bit sr, input bit rr, input bit mb, input bit clr);
        int eff;
        if (clr) begin
            m_armed = 0; m_cnt = 0; m_under = 0; m_over = 0;
            m_valid = 0; m_bit = 0; m_gap = 0;
            return;
        end
        eff = m_cnt + (rr ? 1 : 0);
        if (eff > 2) eff = 2;
        if (m_armed && sr && eff == 0 && !m_over) m_under = 1;
        if (m_armed && eff == 2 && !m_under) m_over = 1;
        m_valid = sr;
        if (sr) begin
            m_bit = mb; m_gap = eff; m_armed = 1; m_cnt = 0;
        end else begin
            m_cnt = eff;
        end
    endtask

    // One clock: compare, drive, advance the model (R10 alignment).
    task automatic step(input logic s, input logic r, input logic mb, input logic clr);
        @(negedge clk);
        if (cmp_en) begin
            chk("R10", "under", int'(under_range_o), int'(m_under));
            chk("R10", "over", int'(over_range_o), int'(m_over));
            chk("R9", "valid", int'(sample_valid_o), int'(m_valid));
            chk("R9", "bit", int'(sample_bit_o), int'(m_bit));
            chk("R9", "gap", int'(ref_gap_o), m_gap);
        end
        sig_osc_i = s; ref_osc_i = r; mod_bit_i = mb; clear_i = clr;
        for (int i = 3; i > 0; i--) begin
            h_sig[i] = h_sig[i-1]; h_ref[i] = h_ref[i-1]; h_mod[i] = h_mod[i-1];
        end
        h_sig[0] = s; h_ref[0] = r; h_mod[0] = mb;
        model_step(h_sig[2] && !h_sig[3], h_ref[2] && !h_ref[3], h_mod[2], clr);
        cyc++;
    endtask

    function automatic logic sq(input int t, input int per, input int ph);
        return ((t + ph) % per) < (per / 2);
    endfunction

    // Run both oscillators; ref_hold freezes the reference at ref_lvl.
    task automatic run(input int n, input int ps, input int phs, input int pr, input int phr,
                       input logic mb, input bit ref_hold, input logic ref_lvl, input bit sig_off);
        for (int i = 0; i < n; i++) begin
            step(sig_off ? 1'b0 : sq(cyc, ps, phs),
                 ref_hold ? ref_lvl : sq(cyc, pr, phr), mb, 1'b0);
        end
    endtask

    task automatic do_clear();
        step(sig_osc_i, ref_osc_i, mod_bit_i, 1'b1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int seed;
        int pr, ps, cls;
        logic mb;
        for (int i = 0; i < 4; i++) begin h_sig[i] = 0; h_ref[i] = 0; h_mod[i] = 0; end
        model_step(0, 0, 0, 1);
        seed = $urandom(32'd20240611);

        // Reset phase with quiet inputs.
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0);
        // R1: reset state
        chk("R1", "under after reset", int'(under_range_o), 0);
        chk("R1", "over after reset", int'(over_range_o), 0);
        chk("R1", "gap after reset", int'(ref_gap_o), 0);

        // R8: reference running, signal held low: not armed, no flag.
        run(120, 20, 0, 20, 0, 1'b0, 0, 1'b0, 1);
        chk("R8", "over while unarmed", int'(over_range_o), 0);
        do_clear();

        // R5: equal periods, edges alternate; quantizer bit 1.
        run(400, 20, 0, 20, 7, 1'b1, 0, 1'b0, 0);
        chk("R5", "under in linear", int'(under_range_o), 0);
        chk("R5", "over in linear", int'(over_range_o), 0);
        chk("R9", "gap in linear", int'(ref_gap_o), 1);
        chk("R9", "bit captured", int'(sample_bit_o), 1);

        // R9: simultaneous edges, reference counted first.
        do_clear();
        run(200, 16, 3, 16, 3, 1'b0, 0, 1'b0, 0);
        chk("R9", "gap with coincident edges", int'(ref_gap_o), 1);
        chk("R9", "bit 0 captured", int'(sample_bit_o), 0);
        chk("R5", "no flag coincident", int'(under_range_o | over_range_o), 0);

        // R2: signal faster than reference.
        do_clear();
        run(300, 12, 0, 20, 5, 1'b0, 0, 1'b0, 0);
        chk("R2", "under with fast signal", int'(under_range_o), 1);
        chk("R2", "over with fast signal", int'(over_range_o), 0);

        // R6: sticky through linear stimulus, then cleared.
        run(200, 20, 0, 20, 4, 1'b0, 0, 1'b0, 0);
        chk("R6", "under sticky", int'(under_range_o), 1);
        do_clear();
        @(negedge clk); // outputs after the clear edge
        chk("R6", "under cleared", int'(under_range_o), 0);
        chk("R6", "valid cleared", int'(sample_valid_o), 0);
        step(sig_osc_i, ref_osc_i, mod_bit_i, 1'b0);

        // R3: reference held high, then held low.
        do_clear();
        run(120, 10, 0, 20, 0, 1'b0, 1, 1'b1, 0);
        chk("R3", "under ref held high", int'(under_range_o), 1);
        do_clear();
        run(120, 10, 0, 20, 0, 1'b1, 1, 1'b0, 0);
        chk("R3", "under ref held low", int'(under_range_o), 1);
        chk("R9", "gap none", int'(ref_gap_o), 0);

        // R4: signal slower than reference with quantizer bit 1.
        do_clear();
        run(400, 30, 0, 20, 2, 1'b1, 0, 1'b0, 0);
        chk("R4", "over with bit 1", int'(over_range_o), 1);
        chk("R4", "under with slow signal", int'(under_range_o), 0);

        // R7: switch to an under pattern without clear.
        run(300, 12, 0, 20, 5, 1'b0, 0, 1'b0, 0);
        chk("R7", "under locked out", int'(under_range_o), 0);
        chk("R7", "over kept", int'(over_range_o), 1);

        // R4 with bit 0, then R6 clear while the reference keeps running.
        do_clear();
        run(400, 30, 0, 20, 2, 1'b0, 0, 1'b0, 0);
        chk("R4", "over with bit 0", int'(over_range_o), 1);

        // Random period ratios with a fixed seed.
        for (int k = 0; k < 30; k++) begin
            pr  = 16 + int'($urandom_range(14));
            cls = int'($urandom_range(2));
            mb  = logic'($urandom_range(1));
            ps  = (cls == 0) ? pr : ((cls == 1) ? (pr * 2) / 3 : (pr * 3) / 2);
            do_clear();
            run(30 * pr, ps, int'($urandom_range(ps - 1)), pr, int'($urandom_range(pr - 1)),
                mb, 0, 1'b0, 0);
            if (cls == 0) begin
                chk("R5", "random linear no flag", int'(under_range_o | over_range_o), 0);
            end else if (cls == 1) begin
                chk("R2", "random under", int'(under_range_o), 1);
            end else begin
                chk("R4", "random over", int'(over_range_o), 1);
            end
            chk("R7", "random exclusive", int'(under_range_o & over_range_o), 0);
        end

        cmp_en = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule